// File: doc/BRIEF.md
# Two-Level Mapped Interrupt Controller

This block collects a vector of system event inputs and turns them into a smaller set of interrupt lines. Every event has a sticky pending latch and its own enable bit. A programmable table assigns each event to one intermediate channel. A second table assigns each channel to one output line. Several events may share a channel, and several channels may share an output. When more than one enabled pending event reaches the same output, a fixed priority picks a single winner. That winner is reported in a per-output status register.

Software uses a synchronous register port. A write has a strobe, an address and data. A read returns data one cycle after the address. Through this port software can enable and disable events one at a time, acknowledge them, inject them as if their input had fired, program both map tables and read back all state. Output lines 2 to 9 are also presented as an eight-bit host group: host bit k is output line k+2.

Top module: `intmap_ctrl`

Register map (8-bit address, 32-bit data):

| Address | Access | Meaning |
|---|---|---|
| 0x00 | R/W | bit 0 is the global enable |
| 0x01 | W | raise (inject) the event whose index is in data[7:0] |
| 0x02 | W | acknowledge the event whose index is in data[7:0] |
| 0x03 | W | enable the event whose index is in data[7:0] |
| 0x04 | W | disable the event whose index is in data[7:0] |
| 0x08+k | R | pending bits of events 32k to 32k+31 |
| 0x0C+k | R | enable bits of events 32k to 32k+31 |
| 0x10+e | R/W | channel of event e, in data[3:0] |
| 0x60+c | R/W | output line of channel c, in data[3:0] |
| 0x70+o | R | status of output o: bit 31 is the valid flag, bits [7:0] hold the winning event index |

## Requirements
- R1: After a synchronous reset, all of the following are zero: every pending bit, every enable bit, every map entry, the global enable, every output and every read value.
- R2: A high level on evt_in[i] at a clock edge sets pending bit i. That bit stays set after the input drops. It can be read at 0x08+(i/32), bit i%32.
- R3: A write to 0x02 with an index clears that event's pending bit. If the event's input is high in the same cycle, the bit stays set.
- R4: A write to 0x01 with an index below 64 sets that event's pending bit. A write to 0x01 with an index of 64 or more changes nothing.
- R5: A write to 0x03 or 0x04 sets or clears one enable bit. The enable bits can be read at 0x0C+k. A pending event whose enable bit is clear drives no output and is not reported in any status register.
- R6: The channel field of event e, written at 0x10+e in data[3:0], decides which channel the event feeds. The field reads back with the value written.
- R7: The output field of channel c, written at 0x60+c in data[3:0], decides which output line the channel drives. The field reads back with the value written.
- R8: irq_o[o] is high exactly when the global enable is set and at least one enabled pending event routes to output o. Output o is updated one clock edge after the pending state changes.
- R9: Status register 0x70+o reports, among the enabled pending events that route to output o, the event on the lowest-numbered channel, and within that channel the lowest event index. Bit 31 flags that such an event exists. The status register ignores the global enable.
- R10: host_irq[k] equals irq_o[k+2] for k from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 64 | System event inputs, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Read data, one cycle after rd_addr |
| irq_o | output | 10 | Registered output interrupt lines |
| host_irq | output | 8 | Output lines 2 to 9, renumbered 0 to 7 |

## Verification
Some properties are checked on every cycle. The outputs are quiet right after reset. An input held high always leaves its pending bit set. A pending bit can rise without its input only through a single inject write. Enables change by at most one bit per cycle. The lines stay low whenever the global enable was off, and otherwise they follow the status valid flags. Other behaviour depends on the programmed tables and can only be shown by the bench scenarios. That covers routing through both map stages, winner selection when channels and events compete, and ignored out-of-range indices. For these, the bench sweeps every event through a known mapping and compares each output and status register with a model computed independently of the RTL.

// File: rtl/intmap_pkg.sv
package intmap_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_SETP = 8'h01;
  localparam logic [7:0] A_CLRP = 8'h02;
  localparam logic [7:0] A_ENS  = 8'h03;
  localparam logic [7:0] A_ENC  = 8'h04;
  localparam logic [7:0] A_PEND = 8'h08;
  localparam logic [7:0] A_ENRD = 8'h0C;
  localparam logic [7:0] A_EMAP = 8'h10;
  localparam logic [7:0] A_CMAP = 8'h60;
  localparam logic [7:0] A_STAT = 8'h70;
endpackage

// File: rtl/intmap_evt_bank.sv
module intmap_evt_bank #(
  parameter int N_EVT = 64,
  localparam int EW = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic             ens_stb,
  input  logic             enc_stb,
  input  logic [EW-1:0]    idx,
  output logic [N_EVT-1:0] pend_q,
  output logic [N_EVT-1:0] en_q
);
  logic [N_EVT-1:0] one_hot;
  assign one_hot = N_EVT'(1) << idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~(clr_stb ? one_hot : '0)) | evt_in | (set_stb ? one_hot : '0);
      en_q   <= (en_q | (ens_stb ? one_hot : '0)) & ~(enc_stb ? one_hot : '0);
    end
  end
endmodule

// File: rtl/intmap_table.sv
module intmap_table #(
  parameter int DEPTH = 64,
  parameter int W = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  q [DEPTH]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (we) begin
      q[wa] <= wd;
    end
  end
endmodule

// File: rtl/intmap_route.sv
module intmap_route #(
  parameter int N_EVT = 64,
  parameter int N_CHN = 10,
  parameter int N_OUT = 10,
  localparam int EW = $clog2(N_EVT),
  localparam int CW = $clog2(N_CHN),
  localparam int OW = $clog2(N_OUT)
) (
  input  logic [N_EVT-1:0] act,
  input  logic [CW-1:0]    emap [N_EVT],
  input  logic [OW-1:0]    cmap [N_CHN],
  output logic [N_OUT-1:0] out_hit,
  output logic [EW-1:0]    out_idx [N_OUT]
);
  logic [N_CHN-1:0] ch_hit;
  logic [EW-1:0]    ch_idx [N_CHN];

  // first stage: lowest active event per channel
  always_comb begin
    for (int c = 0; c < N_CHN; c++) begin
      ch_hit[c] = 1'b0;
      ch_idx[c] = '0;
      for (int e = N_EVT - 1; e >= 0; e--) begin
        if (act[e] && emap[e] == CW'(c)) begin
          ch_hit[c] = 1'b1;
          ch_idx[c] = EW'(e);
        end
      end
    end
  end

  // second stage: lowest active channel per output
  always_comb begin
    for (int o = 0; o < N_OUT; o++) begin
      out_hit[o] = 1'b0;
      out_idx[o] = '0;
      for (int c = N_CHN - 1; c >= 0; c--) begin
        if (ch_hit[c] && cmap[c] == OW'(o)) begin
          out_hit[o] = 1'b1;
          out_idx[o] = ch_idx[c];
        end
      end
    end
  end
endmodule

// File: rtl/intmap_ctrl.sv
module intmap_ctrl
  import intmap_pkg::*;
#(
  parameter int N_EVT = 64,
  parameter int N_CHN = 10,
  parameter int N_OUT = 10,
  parameter int HOST_BASE = 2,
  parameter int N_HOST = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  evt_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_OUT-1:0]  irq_o,
  output logic [N_HOST-1:0] host_irq
);
  localparam int EW = $clog2(N_EVT);
  localparam int CW = $clog2(N_CHN);
  localparam int OW = $clog2(N_OUT);
  localparam int N_WORD = (N_EVT + DATA_W - 1) / DATA_W;
  localparam logic [7:0] EMAP_END = 8'(int'(A_EMAP) + N_EVT);
  localparam logic [7:0] CMAP_END = 8'(int'(A_CMAP) + N_CHN);

  logic             glob_en;
  logic [N_EVT-1:0] pend_vec, en_vec;
  logic [CW-1:0]    emap_q [N_EVT];
  logic [OW-1:0]    cmap_q [N_CHN];
  logic [N_OUT-1:0] out_hit, stat_vld;
  logic [EW-1:0]    out_idx [N_OUT];
  logic [EW-1:0]    stat_idx [N_OUT];
  logic             idx_ok, emap_we, cmap_we;
  logic [DATA_W-1:0] rd_mux;
  logic [N_WORD*DATA_W-1:0] pend_pad, en_pad;

  assign idx_ok  = 32'(wr_data[7:0]) < N_EVT;
  assign emap_we = wr_en && wr_addr >= A_EMAP && wr_addr < EMAP_END;
  assign cmap_we = wr_en && wr_addr >= A_CMAP && wr_addr < CMAP_END;

  intmap_evt_bank #(.N_EVT(N_EVT)) u_bank (
    .clk(clk), .rst(rst), .evt_in(evt_in),
    .set_stb(wr_en && wr_addr == A_SETP && idx_ok),
    .clr_stb(wr_en && wr_addr == A_CLRP && idx_ok),
    .ens_stb(wr_en && wr_addr == A_ENS && idx_ok),
    .enc_stb(wr_en && wr_addr == A_ENC && idx_ok),
    .idx(wr_data[EW-1:0]), .pend_q(pend_vec), .en_q(en_vec)
  );

  intmap_table #(.DEPTH(N_EVT), .W(CW)) u_emap (
    .clk(clk), .rst(rst), .we(emap_we), .wa(EW'(wr_addr - A_EMAP)),
    .wd(wr_data[CW-1:0]), .q(emap_q)
  );

  intmap_table #(.DEPTH(N_CHN), .W(OW)) u_cmap (
    .clk(clk), .rst(rst), .we(cmap_we), .wa(CW'(wr_addr - A_CMAP)),
    .wd(wr_data[OW-1:0]), .q(cmap_q)
  );

  intmap_route #(.N_EVT(N_EVT), .N_CHN(N_CHN), .N_OUT(N_OUT)) u_route (
    .act(pend_vec & en_vec), .emap(emap_q), .cmap(cmap_q),
    .out_hit(out_hit), .out_idx(out_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en  <= 1'b0;
      irq_o    <= '0;
      stat_vld <= '0;
      for (int o = 0; o < N_OUT; o++) stat_idx[o] <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) glob_en <= wr_data[0];
      irq_o    <= glob_en ? out_hit : '0;
      stat_vld <= out_hit;
      for (int o = 0; o < N_OUT; o++) stat_idx[o] <= out_idx[o];
    end
  end

  assign host_irq = irq_o[HOST_BASE +: N_HOST];
  assign pend_pad = (N_WORD*DATA_W)'(pend_vec);
  assign en_pad   = (N_WORD*DATA_W)'(en_vec);

  always_comb begin
    rd_mux = '0;
    if (rd_addr == A_CTRL) rd_mux[0] = glob_en;
    for (int k = 0; k < N_WORD; k++) begin
      if (rd_addr == 8'(int'(A_PEND) + k)) rd_mux = pend_pad[k*DATA_W +: DATA_W];
      if (rd_addr == 8'(int'(A_ENRD) + k)) rd_mux = en_pad[k*DATA_W +: DATA_W];
    end
    if (rd_addr >= A_EMAP && rd_addr < EMAP_END)
      rd_mux = DATA_W'(emap_q[EW'(rd_addr - A_EMAP)]);
    if (rd_addr >= A_CMAP && rd_addr < CMAP_END)
      rd_mux = DATA_W'(cmap_q[CW'(rd_addr - A_CMAP)]);
    for (int o = 0; o < N_OUT; o++) begin
      if (rd_addr == 8'(int'(A_STAT) + o)) begin
        rd_mux[DATA_W-1] = stat_vld[o];
        rd_mux[EW-1:0]   = stat_idx[o];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/intmap_ctrl_chk.sv
module intmap_ctrl_chk
  import intmap_pkg::*;
#(
  parameter int N_EVT = 64,
  parameter int N_OUT = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [N_EVT-1:0] evt_in,
  input logic [N_EVT-1:0] pend_q,
  input logic [N_EVT-1:0] en_q,
  input logic             glob_en,
  input logic [N_OUT-1:0] irq_o,
  input logic [N_OUT-1:0] stat_vld,
  input logic             wr_en,
  input logic [7:0]       wr_addr
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_o == '0 && pend_q == '0 && en_q == '0));

  a_r3_input_holds: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(evt_in) & ~pend_q) == '0));

  a_r4_single_inject: assert property (@(posedge clk) disable iff (rst)
    $countones(pend_q & ~$past(pend_q) & ~$past(evt_in))
      <= (($past(wr_en) && $past(wr_addr) == A_SETP) ? 1 : 0));

  a_r5_one_enable_step: assert property (@(posedge clk) disable iff (rst)
    $countones(en_q ^ $past(en_q)) <= 1);

  a_r8_global_gate: assert property (@(posedge clk) disable iff (rst)
    !$past(glob_en) |-> irq_o == '0);

  a_r9_line_follows_status: assert property (@(posedge clk) disable iff (rst)
    $past(glob_en) |-> irq_o == stat_vld);
endmodule

bind intmap_ctrl intmap_ctrl_chk #(.N_EVT(N_EVT), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .evt_in(evt_in), .pend_q(pend_vec), .en_q(en_vec),
  .glob_en(glob_en), .irq_o(irq_o), .stat_vld(stat_vld),
  .wr_en(wr_en), .wr_addr(wr_addr)
);

// File: tb/intmap_ctrl_tb.sv
module intmap_ctrl_tb;
  import intmap_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 64;
  localparam int NC = 10;
  localparam int NO = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NE-1:0] evt_in = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [NO-1:0] irq_o;
  logic [7:0]  host_irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int emap_m [NE];
  int cmap_m [NC];
  bit en_m   [NE];
  bit pend_m [NE];
  bit glob_m;

  intmap_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_o(irq_o), .host_irq(host_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic set_ev(int e);   wr(A_SETP, 32'(e)); if (e < NE) pend_m[e] = 1; endtask
  task automatic ack_ev(int e);   wr(A_CLRP, 32'(e)); pend_m[e] = 0; endtask
  task automatic en_ev(int e);    wr(A_ENS, 32'(e)); en_m[e] = 1; endtask
  task automatic dis_ev(int e);   wr(A_ENC, 32'(e)); en_m[e] = 0; endtask

  // expected winner: lowest channel, then lowest event
  task automatic exp_win(int o, output bit v, output int idx);
    v = 0; idx = 0;
    for (int c = 0; c < NC && !v; c++)
      if (cmap_m[c] == o)
        for (int e = 0; e < NE && !v; e++)
          if (en_m[e] && pend_m[e] && emap_m[e] == c) begin v = 1; idx = e; end
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    logic [NO-1:0] exp_irq;
    bit v; int idx;
    tick(1);
    for (int o = 0; o < NO; o++) begin
      exp_win(o, v, idx);
      exp_irq[o] = glob_m & v;
      rd(A_STAT + 8'(o), d);
      chk({tag, " R9 status"}, d, {v, 23'd0, 8'(v ? idx : 0)});
    end
    chk({tag, " R8 irq"}, 32'(irq_o), 32'(exp_irq));
    chk({tag, " R10 host"}, 32'(host_irq), 32'(exp_irq[9:2]));
    for (int k = 0; k < 2; k++) begin
      logic [31:0] w = '0;
      for (int b = 0; b < 32; b++) w[b] = pend_m[k*32+b];
      rd(A_PEND + 8'(k), d);
      chk({tag, " R2 pending word"}, d, w);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int e = 0; e < NE; e++) begin emap_m[e] = 0; en_m[e] = 0; pend_m[e] = 0; end
    for (int c = 0; c < NC; c++) cmap_m[c] = 0;
    glob_m = 0;
    tick(3);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    chk("R1 irq", 32'(irq_o), 0);
    rd(A_CTRL, d); chk("R1 ctrl", d, 0);
    for (int k = 0; k < 2; k++) begin
      rd(A_PEND + 8'(k), d); chk("R1 pend", d, 0);
      rd(A_ENRD + 8'(k), d); chk("R1 en", d, 0);
    end
    for (int e = 0; e < NE; e++) begin rd(A_EMAP + 8'(e), d); chk("R1 emap", d, 0); end
    for (int c = 0; c < NC; c++) begin rd(A_CMAP + 8'(c), d); chk("R1 cmap", d, 0); end

    // R6 R7 program tables and read back
    for (int e = 0; e < NE; e++) begin
      emap_m[e] = (e * 7 + 3) % NC; wr(A_EMAP + 8'(e), 32'(emap_m[e]));
    end
    for (int c = 0; c < NC; c++) begin
      cmap_m[c] = (c * 3 + 1) % NO; wr(A_CMAP + 8'(c), 32'(cmap_m[c]));
    end
    for (int e = 0; e < NE; e++) begin rd(A_EMAP + 8'(e), d); chk("R6 emap readback", d, 32'(emap_m[e])); end
    for (int c = 0; c < NC; c++) begin rd(A_CMAP + 8'(c), d); chk("R7 cmap readback", d, 32'(cmap_m[c])); end

    wr(A_CTRL, 1); glob_m = 1;
    rd(A_CTRL, d); chk("R8 ctrl readback", d, 1);

    // R4 R3 R6 R7 sweep: each event alone through both map stages
    for (int e = 0; e < NE; e++) begin
      en_ev(e);
      set_ev(e);
      check_all("R4 R6 R7 sweep set");
      ack_ev(e);
      check_all("R3 sweep ack");
      dis_ev(e);
    end

    // R4 out-of-range inject ignored
    set_ev(64); set_ev(200);
    check_all("R4 out-of-range");

    // R5 disabled pending drives nothing; enable readback
    set_ev(5);
    check_all("R5 disabled pending");
    en_ev(5);
    rd(A_ENRD, d); chk("R5 enable word", d, 32'h20);
    check_all("R5 enabled");
    dis_ev(5);
    rd(A_ENRD, d); chk("R5 enable cleared", d, 0);
    check_all("R5 disabled again");
    ack_ev(5);

    // R2 R9 simultaneous pulses on inputs, all enabled
    for (int e = 0; e < NE; e++) en_ev(e);
    @(negedge clk);
    evt_in = '0;
    evt_in[63] = 1; evt_in[40] = 1; evt_in[17] = 1; evt_in[8] = 1;
    evt_in[3] = 1; evt_in[22] = 1; evt_in[55] = 1; evt_in[13] = 1;
    for (int e = 0; e < NE; e++) if (evt_in[e]) pend_m[e] = 1;
    @(negedge clk);
    evt_in = '0;
    check_all("R2 R9 multi");
    ack_ev(3);  check_all("R9 after ack 3");
    ack_ev(13); check_all("R9 after ack 13");
    ack_ev(40); check_all("R9 after ack 40");

    // R9 R7 all channels onto output 4: lowest channel wins
    for (int c = 0; c < NC; c++) begin cmap_m[c] = 4; wr(A_CMAP + 8'(c), 4); end
    check_all("R9 R7 shared output");
    ack_ev(17); check_all("R9 shared after ack 17");

    // R8 global enable off: lines low, status kept
    wr(A_CTRL, 0); glob_m = 0;
    check_all("R8 global off");
    wr(A_CTRL, 1); glob_m = 1;
    check_all("R8 global on");
    for (int e = 0; e < NE; e++) if (pend_m[e]) ack_ev(e);
    check_all("R3 all cleared");

    // R3 held input defeats acknowledge
    @(negedge clk); evt_in[12] = 1; pend_m[12] = 1;
    tick(2);
    wr(A_CLRP, 12);
    check_all("R3 held input");
    @(negedge clk); evt_in[12] = 0;
    ack_ev(12);
    check_all("R3 released input");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule